// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes a frame that address filtering has already accepted, arriving one byte per transfer on a valid/ready stream. It places the frame into receive buffers that software has posted in a ring of 16-byte descriptors in memory. The frame data is followed by a CRC-32 that the block computes itself and writes out as four trailing bytes. The frame is split across as many buffers as the programmable buffer size requires.

For each buffer, the block reads the descriptor and the buffer address it holds. It writes the bytes through a 32-bit word port with byte enables. It then writes the descriptor back with the byte count, the first and last markers, the classification flags and the ready-for-software bit. After that it steps to the next descriptor, or wraps to the ring base when the descriptor carries the end-of-ring mark.

The block reports three interrupt conditions as one-cycle set pulses:
- packet stored in buffers;
- packet received;
- no buffer available.

A ring base write moves the descriptor pointer back to the new base.

Top module: `rxring_writer`

## Requirements
- R1: Before each buffer the block reads descriptor word 0 at the pointer, then word 3 at pointer+12. If word 0 bit 31 is already set, or either read returns memErr with memAck, then:
  - irqSet[2] pulses in that acknowledge cycle;
  - nothing is written;
  - the remaining stream bytes of the frame are accepted and discarded;
  - the pointer does not move.
- R2: If bufSize is 0 when word 0 is acknowledged, the frame is dropped in the same way as in R1: irqSet[2] pulses and nothing is written.
- R3: A buffer receives min(bytes remaining, bufSize) bytes starting at the word-aligned address held in word 3. Byte k of the buffer goes to lane k mod 4 (bits 8*lane+7:8*lane) of the word at address+4*(k/4), and memBe marks the written lanes.
- R4: The bytes stored are the frame data followed by the CRC-32 of the data: reflected polynomial 0xEDB88320, initial value all ones, final inversion. The CRC is stored most significant byte first and may be split across two buffers.
- R5: Each descriptor write-back is the fetched word 0 ORed with:
  - the buffer byte count in bits 13:0;
  - bit 31 (ready for software);
  - bit 29 on the first buffer of a frame only.
- R6: The last buffer of a frame also sets bit 28 and copies inFlags, as latched with inLast, into bits 16 (bit 0, multicast), 17 (bit 1, broadcast) and 20 (bit 2, oversize). irqSet[0] and irqSet[1] pulse together in the cycle its write-back is acknowledged.
- R7: After each write-back the pointer advances by 16 bytes. It returns to the ring base instead when the end-of-ring bit of the fetched word 0 is set. That bit is bit 15 when eorAltSel is 0 and bit 30 when it is 1; the other bit has no effect.
- R8: A pulse on baseWrEn loads baseWrData as the ring base, and the next fetch reads the descriptor at that base.
- R9: After reset inReady, memReq and irqSet are 0. inReady is 0 whenever memReq is 1, and a request holds its address, direction and data until memAck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baseWrEn | input | 1 | Ring base write strobe |
| baseWrData | input | ADDR_W | New ring base address |
| bufSize | input | 14 | Bytes per receive buffer |
| eorAltSel | input | 1 | End-of-ring bit select: 0 uses bit 15, 1 uses bit 30 |
| inValid | input | 1 | Frame byte valid |
| inData | input | 8 | Frame byte |
| inLast | input | 1 | Last data byte of the frame |
| inFlags | input | 3 | Classification {oversize, broadcast, multicast}, sampled with inLast |
| inReady | output | 1 | Byte accepted when high with inValid |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | ADDR_W | Byte address, word aligned |
| memWdata | output | 32 | Write data |
| memBe | output | 4 | Write byte enables |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Request accepted |
| memErr | input | 1 | Read failed, valid with memAck |
| irqSet | output | 3 | Set pulses: [0] stored in buffers, [1] received, [2] no buffer |

## Verification
The checker watches several rules on every cycle:
- the stream is stalled while a memory request is outstanding;
- a request holds its address, direction and data until accepted;
- the two completion pulses occur only together, exactly when a full-word write carrying the ready and last bits is accepted;
- the no-buffer pulse occurs only on an accepted read.

Only the bench scenarios can show that the right bytes land in the right lanes, that the trailing CRC has the correct value and byte order, and that counts and flags are correct when a frame spans several buffers. The same holds for end-of-ring wrap under both bit selections, redirection after a base write, and the fact that a dropped frame is drained without moving the pointer.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  // Descriptor geometry and word-0 bit positions (software decodes these)
  localparam int unsigned DESC_BYTES = 16;
  localparam int unsigned W3_OFS     = 12;
  localparam int unsigned LEN_W      = 14;
  localparam int unsigned RDY_BIT    = 31;
  localparam int unsigned EOR_ALT    = 30;
  localparam int unsigned FRS_BIT    = 29;
  localparam int unsigned LRS_BIT    = 28;
  localparam int unsigned OVS_BIT    = 20;
  localparam int unsigned BC_BIT     = 17;
  localparam int unsigned MC_BIT     = 16;
  localparam int unsigned EOR_STD    = 15;

  typedef enum logic [2:0] {
    S_IDLE, S_RD0, S_RD3, S_FILL, S_WRDATA, S_WRDESC, S_DRAIN
  } rxState_t;

  typedef enum logic [1:0] {A_W0, A_W3, A_DATA, A_DESC} rxAddrSel_t;

  typedef struct packed {
    logic       startFrame;
    logic       ldWord0;
    logic       ldWord3;
    logic       takeByte;
    logic       wordDone;
    logic       descDone;
    rxAddrSel_t addrSel;
  } rxStrobe_t;

  typedef struct packed {
    logic byteAvail;
    logic laneLast;
    logic bufEnd;
    logic finalByte;
    logic frameDone;
    logic bufFull;
    logic bufZero;
    logic rdySet;
    logic phaseCrc;
  } rxView_t;

  // One byte of reflected CRC-32
  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rxring_dp.sv
module rxring_dp
  import rxring_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  output rxView_t           view,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic [LEN_W-1:0]  bufSize,
  input  logic              eorAltSel,
  input  logic              inValid,
  input  logic [7:0]        inData,
  input  logic              inLast,
  input  logic [2:0]        inFlags,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memBe
);
  localparam int unsigned WI_W = LEN_W - 2;

  logic [ADDR_W-1:0] ringBase, descPtr, bufAddr;
  logic [31:0]       word0Q, accum, crcQ, crcOut, wbWord;
  logic [3:0]        beQ;
  logic [1:0]        lane, crcIdx;
  logic [LEN_W-1:0]  cnt;
  logic [WI_W-1:0]   wordIdx;
  logic              phaseCrc, firstBuf, frameDone, eorHit;
  logic [2:0]        flagsQ;
  logic [7:0]        curByte;

  always_comb begin
    case (crcIdx)
      2'd0:    curByte = crcOut[31:24];
      2'd1:    curByte = crcOut[23:16];
      2'd2:    curByte = crcOut[15:8];
      default: curByte = crcOut[7:0];
    endcase
    if (!phaseCrc) curByte = inData;
  end

  assign eorHit = eorAltSel ? word0Q[EOR_ALT] : word0Q[EOR_STD];

  assign view.byteAvail = phaseCrc || inValid;
  assign view.laneLast  = (lane == 2'd3);
  assign view.bufEnd    = ({1'b0, cnt} + (LEN_W+1)'(1)) == {1'b0, bufSize};
  assign view.finalByte = phaseCrc && (crcIdx == 2'd3);
  assign view.frameDone = frameDone;
  assign view.bufFull   = (cnt == bufSize);
  assign view.bufZero   = (bufSize == '0);
  assign view.rdySet    = memRdata[RDY_BIT];
  assign view.phaseCrc  = phaseCrc;

  always_comb begin
    wbWord = word0Q;
    wbWord[LEN_W-1:0] = word0Q[LEN_W-1:0] | cnt;
    wbWord[RDY_BIT] = 1'b1;
    if (firstBuf) wbWord[FRS_BIT] = 1'b1;
    if (frameDone) begin
      wbWord[LRS_BIT] = 1'b1;
      wbWord[MC_BIT]  = word0Q[MC_BIT]  | flagsQ[0];
      wbWord[BC_BIT]  = word0Q[BC_BIT]  | flagsQ[1];
      wbWord[OVS_BIT] = word0Q[OVS_BIT] | flagsQ[2];
    end
  end

  always_comb begin
    memWdata = wbWord;
    memBe    = 4'hF;
    unique case (strb.addrSel)
      A_W0, A_DESC: memAddr = descPtr;
      A_W3:         memAddr = descPtr + ADDR_W'(W3_OFS);
      default: begin
        memAddr  = bufAddr + ADDR_W'({wordIdx, 2'b00});
        memWdata = accum;
        memBe    = beQ;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ringBase <= '0; descPtr <= '0; bufAddr <= '0; word0Q <= '0;
      accum <= '0; crcQ <= '1; crcOut <= '0; beQ <= '0; lane <= '0;
      crcIdx <= '0; cnt <= '0; wordIdx <= '0; phaseCrc <= 1'b0;
      firstBuf <= 1'b0; frameDone <= 1'b0; flagsQ <= '0;
    end else begin
      if (strb.startFrame) begin
        crcQ <= '1; phaseCrc <= 1'b0; crcIdx <= '0; firstBuf <= 1'b1;
        frameDone <= 1'b0; cnt <= '0; wordIdx <= '0; lane <= '0;
        accum <= '0; beQ <= '0;
      end
      if (strb.ldWord0) word0Q <= memRdata;
      if (strb.ldWord3) bufAddr <= memRdata[ADDR_W-1:0];
      if (strb.takeByte) begin
        accum[8*lane +: 8] <= curByte;
        beQ[lane] <= 1'b1;
        lane <= lane + 2'd1;
        cnt  <= cnt + LEN_W'(1);
        if (!phaseCrc) begin
          crcQ <= crcStep(crcQ, inData);
          if (inLast) begin
            phaseCrc <= 1'b1;
            crcOut   <= ~crcStep(crcQ, inData);
            flagsQ   <= inFlags;
          end
        end else begin
          crcIdx <= crcIdx + 2'd1;
          if (crcIdx == 2'd3) frameDone <= 1'b1;
        end
      end
      if (strb.wordDone) begin
        accum <= '0; beQ <= '0; lane <= '0;
        wordIdx <= wordIdx + WI_W'(1);
      end
      if (strb.descDone) begin
        firstBuf <= 1'b0; cnt <= '0; wordIdx <= '0;
        descPtr  <= eorHit ? ringBase : descPtr + ADDR_W'(DESC_BYTES);
      end
      if (baseWrEn) begin
        ringBase <= baseWrData;
        descPtr  <= baseWrData;
      end
    end
  end
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  rxView_t   view,
  input  logic      inValid,
  input  logic      inLast,
  input  logic      memAck,
  input  logic      memErr,
  output rxStrobe_t strb,
  output logic      inReady,
  output logic      memReq,
  output logic      memWe,
  output logic [2:0] irqSet
);
  rxState_t state, nxt;

  always_comb begin
    strb = '0; nxt = state; memReq = 1'b0; memWe = 1'b0;
    inReady = 1'b0; irqSet = '0;
    strb.addrSel = A_W0;
    unique case (state)
      S_IDLE: if (inValid) begin strb.startFrame = 1'b1; nxt = S_RD0; end
      S_RD0: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr || view.rdySet || view.bufZero) begin
            irqSet[2] = 1'b1;
            nxt = view.phaseCrc ? S_IDLE : S_DRAIN;
          end else begin
            strb.ldWord0 = 1'b1; nxt = S_RD3;
          end
        end
      end
      S_RD3: begin
        memReq = 1'b1; strb.addrSel = A_W3;
        if (memAck) begin
          if (memErr) begin
            irqSet[2] = 1'b1;
            nxt = view.phaseCrc ? S_IDLE : S_DRAIN;
          end else begin
            strb.ldWord3 = 1'b1; nxt = S_FILL;
          end
        end
      end
      S_FILL: begin
        inReady = !view.phaseCrc;
        if (view.byteAvail) begin
          strb.takeByte = 1'b1;
          if (view.laneLast || view.bufEnd || view.finalByte) nxt = S_WRDATA;
        end
      end
      S_WRDATA: begin
        memReq = 1'b1; memWe = 1'b1; strb.addrSel = A_DATA;
        if (memAck) begin
          strb.wordDone = 1'b1;
          nxt = (view.frameDone || view.bufFull) ? S_WRDESC : S_FILL;
        end
      end
      S_WRDESC: begin
        memReq = 1'b1; memWe = 1'b1; strb.addrSel = A_DESC;
        if (memAck) begin
          strb.descDone = 1'b1;
          if (view.frameDone) begin irqSet[1:0] = 2'b11; nxt = S_IDLE; end
          else nxt = S_RD0;
        end
      end
      default: begin
        inReady = 1'b1;
        if (inValid && inLast) nxt = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic [13:0]       bufSize,
  input  logic              eorAltSel,
  input  logic              inValid,
  input  logic [7:0]        inData,
  input  logic              inLast,
  input  logic [2:0]        inFlags,
  output logic              inReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memBe,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  input  logic              memErr,
  output logic [2:0]        irqSet
);
  rxStrobe_t strb;
  rxView_t   view;

  rxring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .view(view), .inValid(inValid), .inLast(inLast),
    .memAck(memAck), .memErr(memErr), .strb(strb), .inReady(inReady),
    .memReq(memReq), .memWe(memWe), .irqSet(irqSet)
  );

  rxring_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .view(view), .baseWrEn(baseWrEn),
    .baseWrData(baseWrData), .bufSize(bufSize), .eorAltSel(eorAltSel),
    .inValid(inValid), .inData(inData), .inLast(inLast), .inFlags(inFlags),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe)
  );
endmodule

// File: rtl/rxring_chk.sv
module rxring_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWdata,
  input logic [3:0]        memBe,
  input logic [2:0]        irqSet
);
  p_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !inReady);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  p_done_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqSet[0] |-> (memReq && memWe && memAck && memBe == 4'hF && memWdata[31] && memWdata[28]));

  p_pair_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqSet[1] |-> irqSet[0]);

  p_nobuf_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    irqSet[2] |-> (memReq && !memWe && memAck && !irqSet[0]));
endmodule

bind rxring_writer rxring_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .memReq(memReq), .memWe(memWe),
  .memAck(memAck), .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe),
  .irqSet(irqSet)
);

// File: tb/rxring_writer_test.sv
`timescale 1ns/1ps
module rxring_writer_test;
  localparam int unsigned ADDR_W = 32;
  // {alt[28], flags[26:24], bufSize[23:16], len[15:0]}
  localparam logic [31:0] VEC [0:5] = '{
    32'h0080_003C, 32'h0140_003D, 32'h1220_0064,
    32'h0421_001E, 32'h0305_0001, 32'h1003_0007
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic baseWrEn = 1'b0, eorAltSel = 1'b0, inValid = 1'b0, inLast = 1'b0;
  logic [ADDR_W-1:0] baseWrData = '0, memAddr;
  logic [13:0] bufSize = 14'd64;
  logic [7:0] inData = '0;
  logic [2:0] inFlags = '0, irqSet;
  logic inReady, memReq, memWe, memAck, memErr;
  logic [31:0] memWdata, memRdata;
  logic [3:0] memBe;

  rxring_writer #(.ADDR_W(ADDR_W)) uut (.*);

  always #5 clk = ~clk;

  logic [31:0] mem [0:1023];
  logic waitQ = 1'b0;
  logic [ADDR_W-1:0] errAddr = 32'hFFFF_FFF0;
  assign memAck   = memReq && waitQ;
  assign memRdata = mem[memAddr[11:2]];
  assign memErr   = memAck && (memAddr == errAddr);
  always @(posedge clk) begin
    waitQ <= memReq && !memAck;
    if (memAck && memWe)
      for (int b = 0; b < 4; b++)
        if (memBe[b]) mem[memAddr[11:2]][8*b +: 8] <= memWdata[8*b +: 8];
  end

  int pktCnt = 0, fifoCnt = 0, nobufCnt = 0, overlap = 0;
  always @(negedge clk) begin
    if (irqSet[0]) pktCnt++;
    if (irqSet[1]) fifoCnt++;
    if (irqSet[2]) nobufCnt++;
    if (inReady && memReq) overlap++;
  end

  int checks = 0, fails = 0;
  logic [7:0] frm [0:255];
  logic [2:0] frmFlags;
  logic [31:0] origW0 [0:3];
  int slotQ;
  logic altQ;

  task automatic check(input bit ok, input string req, input int unsigned act, input int unsigned expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%08h exp=0x%08h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] memByte(input int a);
    return mem[a >> 2][8*(a % 4) +: 8];
  endfunction

  function automatic logic [31:0] refCrc(input int len);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < len; i++)
      for (int k = 0; k < 8; k++) begin
        fb = c[0] ^ frm[i][k];
        c = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    return ~c;
  endfunction

  task automatic baseWrite(input logic [31:0] a);
    @(negedge clk); baseWrEn = 1'b1; baseWrData = a;
    @(negedge clk); baseWrEn = 1'b0;
  endtask

  task automatic initRing(input logic alt);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w0;
      w0 = '0;
      if (i == 3) w0 = alt ? 32'h4000_0000 : 32'h0000_8000;
      if (i == 1) w0 = alt ? 32'h0000_8000 : 32'h4000_0000;
      origW0[i] = w0;
      mem[(32'h100 + 16*i) >> 2]     = w0;
      mem[(32'h100 + 16*i + 4) >> 2] = '0;
      mem[(32'h100 + 16*i + 8) >> 2] = '0;
      mem[(32'h100 + 16*i + 12) >> 2] = 32'h400 + 32'h100*i;
    end
    for (int w = 256; w < 512; w++) mem[w] = '0;
    altQ = alt; eorAltSel = alt;
    baseWrite(32'h100);
    slotQ = 0;
  endtask

  task automatic fillFrame(input int len, input int seed);
    for (int i = 0; i < len; i++) frm[i] = 8'((i * 7 + seed) & 255);
  endtask

  task automatic sendFrame(input int len);
    for (int i = 0; i < len; i++) begin
      inValid = 1'b1; inData = frm[i]; inLast = (i == len - 1); inFlags = frmFlags;
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0; inLast = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  task automatic checkFrame(input int len, input int bs, input string tag);
    logic [7:0] full [0:271];
    logic [31:0] crc, expv, act;
    int total, off, n, bad;
    bit first, last, eor;
    crc = refCrc(len);
    total = len + 4;
    for (int i = 0; i < len; i++) full[i] = frm[i];
    for (int k = 0; k < 4; k++) full[len + k] = crc[31 - 8*k -: 8];
    off = 0; first = 1'b1;
    while (off < total) begin
      n = (total - off < bs) ? total - off : bs;
      last = (off + n == total);
      expv = origW0[slotQ] | 32'(n) | 32'h8000_0000 | (first ? 32'h2000_0000 : 32'h0);
      if (last) expv = expv | 32'h1000_0000 | (32'(frmFlags[0]) << 16)
                       | (32'(frmFlags[1]) << 17) | (32'(frmFlags[2]) << 20);
      act = mem[(32'h100 + 16*slotQ) >> 2];
      check(act == expv, tag, act, expv);
      bad = 0;
      for (int j = 0; j < n; j++)
        if (memByte(32'h400 + 32'h100*slotQ + j) != full[off + j]) bad++;
      check(bad == 0, "R3 R4 buffer bytes", bad, 0);
      eor = altQ ? origW0[slotQ][30] : origW0[slotQ][15];
      slotQ = eor ? 0 : slotQ + 1;
      off += n; first = 1'b0;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 act=0x%08h exp=0x%08h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int p0, n0;
    for (int w = 0; w < 1024; w++) mem[w] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(inReady == 1'b0, "R9 inReady after reset", 32'(inReady), 0);
    check(memReq == 1'b0, "R9 memReq after reset", 32'(memReq), 0);
    check(irqSet == 3'b000, "R9 irqSet after reset", 32'(irqSet), 0);

    // Table of frames: R3 R4 R5 R6 R7
    for (int v = 0; v < 6; v++) begin
      int len, bs;
      len = int'(VEC[v][15:0]); bs = int'(VEC[v][23:16]);
      frmFlags = VEC[v][26:24];
      initRing(VEC[v][28]);
      bufSize = 14'(bs);
      fillFrame(len, v * 13 + 5);
      p0 = pktCnt; n0 = fifoCnt;
      sendFrame(len);
      checkFrame(len, bs, "R5 R6 R7 word0");
      check(pktCnt == p0 + 1, "R6 stored pulse", pktCnt - p0, 1);
      check(fifoCnt == n0 + 1, "R6 received pulse", fifoCnt - n0, 1);
    end

    // R4 known CRC value, MSB first
    initRing(1'b0); bufSize = 14'd64; frmFlags = 3'b000;
    for (int i = 0; i < 9; i++) frm[i] = 8'h31 + 8'(i);
    sendFrame(9);
    check(memByte(32'h409) == 8'hCB, "R4 crc byte0", memByte(32'h409), 8'hCB);
    check(memByte(32'h40A) == 8'hF4, "R4 crc byte1", memByte(32'h40A), 8'hF4);
    check(memByte(32'h40B) == 8'h39, "R4 crc byte2", memByte(32'h40B), 8'h39);
    check(memByte(32'h40C) == 8'h26, "R4 crc byte3", memByte(32'h40C), 8'h26);

    // R1 descriptor already owned by software
    initRing(1'b0); frmFlags = 3'b001;
    mem[32'h100 >> 2] = 32'h8000_0000;
    fillFrame(20, 3); p0 = pktCnt; n0 = nobufCnt;
    sendFrame(20);
    check(nobufCnt == n0 + 1, "R1 no-buffer pulse", nobufCnt - n0, 1);
    check(pktCnt == p0, "R1 no stored pulse", pktCnt - p0, 0);
    check(mem[32'h400 >> 2] == 0, "R1 buffer untouched", mem[32'h400 >> 2], 0);
    mem[32'h100 >> 2] = '0;
    fillFrame(20, 9);
    sendFrame(20);
    checkFrame(20, 64, "R1 pointer kept after drop");

    // R1 read error on word 3
    initRing(1'b0); errAddr = 32'h10C;
    fillFrame(20, 4); n0 = nobufCnt;
    sendFrame(20);
    errAddr = 32'hFFFF_FFF0;
    check(nobufCnt == n0 + 1, "R1 read error pulse", nobufCnt - n0, 1);
    check(mem[32'h400 >> 2] == 0, "R1 read error no write", mem[32'h400 >> 2], 0);

    // R2 buffer size zero
    initRing(1'b0); bufSize = 14'd0;
    fillFrame(20, 6); n0 = nobufCnt; p0 = pktCnt;
    sendFrame(20);
    check(nobufCnt == n0 + 1, "R2 zero size pulse", nobufCnt - n0, 1);
    check(pktCnt == p0, "R2 zero size no stored pulse", pktCnt - p0, 0);
    check(mem[32'h100 >> 2] == 0, "R2 descriptor unchanged", mem[32'h100 >> 2], 0);
    bufSize = 14'd64;

    // R7 wrap across frames
    initRing(1'b0); frmFlags = 3'b010;
    fillFrame(100, 1); sendFrame(100); checkFrame(100, 64, "R7 frame A");
    fillFrame(100, 2); sendFrame(100); checkFrame(100, 64, "R7 frame B");
    check(slotQ == 0, "R7 model wrapped", slotQ, 0);
    mem[32'h100 >> 2] = origW0[0]; mem[32'h110 >> 2] = origW0[1];
    fillFrame(100, 3); sendFrame(100); checkFrame(100, 64, "R7 frame C after wrap");

    // R8 base write redirects
    initRing(1'b0);
    baseWrite(32'h120); slotQ = 2;
    fillFrame(20, 8); sendFrame(20); checkFrame(20, 64, "R8 lands at new base");
    check(mem[32'h100 >> 2] == 0, "R8 old slot untouched", mem[32'h100 >> 2], 0);

    check(overlap == 0, "R9 stall during memory access", overlap, 0);
    summary();
    $finish;
  end
endmodule